// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a memory device. A 16-state controller advances on the rising edge of the test clock under the mode-select input. It loads a three-bit instruction and places one of three data registers between the serial input and the serial output. The three registers are a boundary register that spans the device pins, a 32-bit identification register, and a one-bit bypass register.

The boundary register captures the input pins, the output pins and a few fixed cells that have no pin. Through an update latch it can take over the device outputs. One instruction instead forces all outputs to high impedance while the boundary register is scanned. The pins are plain vectors. The functional inputs always pass straight through to the core.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows the standard 16-state graph on rising `tck`. From any state, five rising edges with `tms` high reach Test-Logic-Reset. A low `trst_n` forces Test-Logic-Reset at once.
- R2: The instruction register is 3 bits wide and shifts LSB first. The encodings are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD and 111 BYPASS. Capture-IR loads 001. A new instruction takes effect on the falling `tck` edge in Update-IR and not before.
- R3: IDCODE is active after `trst_n` and whenever the controller is in Test-Logic-Reset. Under IDCODE, Capture-DR loads `ID_VALUE`, which is shifted out LSB first over 32 bits.
- R4: BYPASS and the reserved codes 011, 101 and 110 select a one-bit register that captures 0. Data therefore leaves one cycle late, with a leading 0.
- R5: Under EXTEST, SAMPLE/PRELOAD and SAMPLE-Z, Capture-DR loads the boundary register. Bits [N_IN-1:0] take `pin_in`, the next N_OUT bits take `pad_out`, and the top N_FIX bits take `FIX_VAL`. Bit 0 is nearest `tdo`.
- R6: On the falling `tck` edge in Update-DR, a boundary instruction copies the boundary register into the update latch. This is how SAMPLE/PRELOAD preloads the latch.
- R7: Under EXTEST, `pad_out` is the output-cell field of the update latch and `pad_oe` is 1.
- R8: `core_in` always equals `pin_in`, under EXTEST as well.
- R9: Under SAMPLE-Z, `pad_oe` is 0 and the boundary register lies on the scan path.
- R10: Under any other instruction, `pad_out` follows `core_out` and `pad_oe` follows `core_oe`.
- R11: `tdo` and `tdo_en` change on falling `tck`. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 when `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Drive enable for tdo |
| pin_in | input | N_IN | Input pin states |
| core_in | output | N_IN | Input values presented to the core |
| core_out | input | N_OUT | Core output data |
| core_oe | input | 1 | Core output enable |
| pad_out | output | N_OUT | Value driven to output pins |
| pad_oe | output | 1 | Output pin enable |

## Verification
The assertions assume that `tms` and `tdi` are stable around rising `tck`. They also assume that `trst_n` is only asserted while the controller is not mid-scan. The stimulus meets both assumptions by driving every serial input just after a falling edge and by pulsing reset only at the start. The pins and the core values change only while the controller idles in Run-Test-Idle, so each capture sees settled values. Random opcodes cover all eight codes, including the reserved ones, and a model of the update latch is kept in the bench.

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_FIX = 2,
  parameter logic [N_FIX-1:0] FIX_VAL = 2'b10,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_0E3B
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic             core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic             pad_oe
);
  localparam int BSR_LEN = N_IN + N_OUT + N_FIX;
  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_SAMPZ  = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;
  localparam logic [2:0] IR_CAPT   = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t state, nxt;
  logic [2:0] ir, ir_sh;
  logic [BSR_LEN-1:0] bsr, upd;
  logic [31:0] idr;
  logic byp;
  logic sel_bsr, sel_id, dr_out;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  assign sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPLE) || (ir == OP_SAMPZ);
  assign sel_id  = (ir == OP_IDCODE);
  assign dr_out  = sel_bsr ? bsr[0] : (sel_id ? idr[0] : byp);

  assign core_in = pin_in;
  assign pad_out = (ir == OP_EXTEST) ? upd[N_IN +: N_OUT] : core_out;
  assign pad_oe  = (ir == OP_EXTEST) ? 1'b1 : ((ir == OP_SAMPZ) ? 1'b0 : core_oe);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= TLR;
      ir_sh <= '0;
      bsr   <= '0;
      idr   <= '0;
      byp   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == CAP_IR)     ir_sh <= IR_CAPT;
      else if (state == SH_IR) ir_sh <= {tdi, ir_sh[2:1]};
      if (sel_bsr) begin
        if (state == CAP_DR)     bsr <= {FIX_VAL, pad_out, pin_in};
        else if (state == SH_DR) bsr <= {tdi, bsr[BSR_LEN-1:1]};
      end
      if (sel_id) begin
        if (state == CAP_DR)     idr <= ID_VALUE;
        else if (state == SH_DR) idr <= {tdi, idr[31:1]};
      end
      if (state == CAP_DR)     byp <= 1'b0;
      else if (state == SH_DR) byp <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir     <= OP_IDCODE;
      upd    <= '0;
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      if (state == TLR)         ir <= OP_IDCODE;
      else if (state == UPD_IR) ir <= ir_sh;
      if (state == UPD_DR && sel_bsr) upd <= bsr;
      tdo_en <= (state == SH_IR) || (state == SH_DR);
      tdo    <= (state == SH_IR) ? ir_sh[0] : ((state == SH_DR) ? dr_out : 1'b0);
    end
  end

  // R1
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == TLR));
  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_IR) |=> (ir_sh == IR_CAPT));
  // R3
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TLR) |=> (ir == OP_IDCODE));
  // R9
  sampz_hiz_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_SAMPZ) |-> !pad_oe);
  // R11
  tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == SH_IR || state == SH_DR));
endmodule

// File: tb/jtag_bscan_tap_tb.sv
module jtag_bscan_tap_tb;
  localparam int NI = 4, NO = 4, NF = 2, BL = NI + NO + NF;
  localparam logic [NF-1:0] FIXV = 2'b10;
  localparam logic [31:0] IDV = 32'h1A5C_0E3B;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic core_oe = 1'b0;
  logic tdo, tdo_en, pad_oe;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pad_out;

  int vectors = 0, errs = 0;
  logic en_seen, en_ok;
  logic [BL-1:0] upd_m;

  jtag_bscan_tap u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always #4 tck = ~tck;

  initial begin
    #1600000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic go_rti();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic ld_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 3; i++) begin step(i == 2, code[i], o); cap[i] = o; end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0; en_seen = 1'b1;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      en_seen &= tdo_en;
      step(i == len - 1, din[i], o); dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  function automatic logic is_bsr(input logic [2:0] op);
    return op == 3'b000 || op == 3'b100 || op == 3'b010;
  endfunction

  function automatic logic [NO-1:0] exp_pad(input logic [2:0] op);
    return (op == 3'b000) ? upd_m[NI +: NO] : core_out;
  endfunction

  function automatic logic exp_oe(input logic [2:0] op);
    return (op == 3'b000) ? 1'b1 : ((op == 3'b010) ? 1'b0 : core_oe);
  endfunction

  function automatic logic [63:0] exp_capture(input logic [2:0] op);
    return {54'd0, FIXV, exp_pad(op), pin_in};
  endfunction

  function automatic logic [63:0] exp_bypass(input logic [63:0] din, input int len);
    logic [63:0] r = '0;
    for (int i = 1; i < len; i++) r[i] = din[i-1];
    return r;
  endfunction

  initial begin
    logic [2:0] cap, op;
    logic [63:0] dout, pat, pat2;
    logic o;
    void'($urandom(32'd2024));
    upd_m = '0;
    pin_in = 4'hA; core_out = 4'h5; core_oe = 1'b1;
    #20; @(negedge tck); #1; trst_n = 1'b1;
    step(0, 0, o);

    check("R11 reset tdo_en", {63'd0, tdo_en}, 64'd0);
    check("R10 reset pad_out", {60'd0, pad_out}, {60'd0, core_out});
    check("R10 reset pad_oe", {63'd0, pad_oe}, {63'd0, core_oe});
    check("R8 core_in", {60'd0, core_in}, {60'd0, pin_in});

    scan_dr(32, 64'h0, dout);
    check("R3 default idcode", dout, {32'd0, IDV});
    check("R11 tdo_en in shift", {63'd0, en_seen}, 64'd1);
    step(0, 0, o);
    check("R11 tdo_en idle", {63'd0, tdo_en}, 64'd0);

    ld_ir(3'b001, cap);
    check("R2 capture-IR 001", {61'd0, cap}, 64'd1);

    foreach (pat[k]) pat[k] = 1'b0;
    for (int c = 0; c < 4; c++) begin
      op = (c == 0) ? 3'b111 : (c == 1) ? 3'b011 : (c == 2) ? 3'b101 : 3'b110;
      ld_ir(op, cap);
      pat = {$urandom, $urandom};
      scan_dr(9, pat, dout);
      check("R4 bypass/reserved path", dout & 64'h1FF, exp_bypass(pat, 9));
    end

    pin_in = 4'h3; core_out = 4'h9; core_oe = 1'b0;
    ld_ir(3'b100, cap);
    pat = 64'h2C6;
    scan_dr(BL, pat, dout);
    check("R5 sample capture", dout & 64'h3FF, exp_capture(3'b100));
    upd_m = pat[BL-1:0];
    check("R10 sample pads follow core", {59'd0, pad_oe, pad_out}, {59'd0, core_oe, core_out});

    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 3; i++) step(i == 2, 1'b0, o);
    check("R2 no effect before Update-IR", {59'd0, pad_oe, pad_out}, {59'd0, core_oe, core_out});
    step(1, 0, o);
    check("R7 extest pad_out at Update-IR", {60'd0, pad_out}, {60'd0, upd_m[NI +: NO]});
    check("R7 extest pad_oe", {63'd0, pad_oe}, 64'd1);
    step(0, 0, o);

    pin_in = 4'hE;
    #1;
    check("R8 extest inputs unblocked", {60'd0, core_in}, 64'hE);
    pat2 = 64'h135;
    scan_dr(BL, pat2, dout);
    check("R5 extest capture", dout & 64'h3FF, exp_capture(3'b000));
    upd_m = pat2[BL-1:0];
    check("R6 update-DR drives pads", {60'd0, pad_out}, {60'd0, upd_m[NI +: NO]});

    ld_ir(3'b010, cap);
    check("R9 sample-z high-Z", {63'd0, pad_oe}, 64'd0);
    scan_dr(BL, 64'h0, dout);
    check("R9 sample-z boundary path", dout & 64'h3FF, exp_capture(3'b010));
    upd_m = '0;

    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    check("R1 five ones reach reset, R3 idcode", {59'd0, pad_oe, pad_out}, {59'd0, core_oe, core_out});
    step(0, 0, o);
    scan_dr(32, 64'h0, dout);
    check("R3 idcode after reset state", dout, {32'd0, IDV});

    for (int n = 0; n < 24; n++) begin
      op = 3'($urandom);
      pin_in = 4'($urandom); core_out = 4'($urandom); core_oe = 1'($urandom);
      ld_ir(op, cap);
      check("R2 capture-IR", {61'd0, cap}, 64'd1);
      check("R7 R9 R10 pad_oe", {63'd0, pad_oe}, {63'd0, exp_oe(op)});
      check("R7 R10 pad_out", {60'd0, pad_out}, {60'd0, exp_pad(op)});
      check("R8 core_in", {60'd0, core_in}, {60'd0, pin_in});
      pat = {$urandom, $urandom};
      if (is_bsr(op)) begin
        scan_dr(BL, pat, dout);
        check("R5 random capture", dout & 64'h3FF, exp_capture(op));
        upd_m = pat[BL-1:0];
        check("R6 random update", {60'd0, pad_out}, {60'd0, exp_pad(op)});
      end else if (op == 3'b001) begin
        scan_dr(32, pat, dout);
        check("R3 random idcode", dout, {32'd0, IDV});
      end else begin
        scan_dr(12, pat, dout);
        check("R4 random bypass", dout & 64'hFFF, exp_bypass(pat, 12));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule